// File: doc/BRIEF.md
# Serial Idle-Timeout Latch Generator

This block takes a serial bit stream (a data pin plus a serial clock pin) and assembles it in a 224-bit shift register. Both pins are treated as asynchronous. They are sampled in a free-running oscillator clock domain, and the serial clock's rising edges are found there. There is no separate load strobe. The block treats silence on the serial clock as the end of a frame. It counts how many oscillator cycles separated the two most recent serial clock rising edges. Once the line has been quiet for eight times that interval, it checks a 6-bit header held at the top of the shift register.

When the header carries the write code, the block emits a single-cycle latch pulse. On the same clock edge it copies the 218 bits under the header into a parallel output register. That register keeps its value until the next successful latch. A host that clocks at any steady rate will therefore commit its frame a fixed number of its own bit times after the last bit. The wait is clamped between 8 and 16384 oscillator cycles. After a latch, the block ignores serial clock edges for a short guard window.

Top module: `slt_latch_gen`

## Requirements
- R1: While reset is low, and right after it is released, `latch_pulse_o` is 0 and `data_o` is all zeros.
- R2: Each accepted serial clock rising edge shifts the sampled data bit into bit 0 of the 224-bit register, so the first bit of a 224-bit frame ends up in bit 223. Bits 223..218 form the header, and bits 217..0 form the payload, with the last bit sent at `data_o[0]`.
- R3: Let edge 1 be the first oscillator edge that samples the serial clock high. The latch pulse is high for exactly one oscillator cycle, the one that follows edge T+3.
- R4: T = 8·P, clamped to the range 8..16384. P is the number of oscillator cycles between the last two accepted serial clock rising edges.
- R5: A latch happens only if the header equals 6'h25 when the timeout expires. With any other header there is no pulse and `data_o` keeps its value.
- R6: On a latch, `data_o` takes the payload bits 217..0 of the shift register. It holds that value until the next latch.
- R7: An idle interval produces at most one pulse. A new pulse needs a newly accepted serial clock edge first.
- R8: Serial clock rising edges seen during the 8 oscillator cycles after the latch decision are ignored. They do not shift the register, update P or re-arm the detector.
- R9: The interval counter saturates instead of wrapping. An interval longer than 32767 cycles still gives T = 16384.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock pin (asynchronous) |
| sdat_i | input | 1 | Serial data pin (asynchronous) |
| latch_pulse_o | output | 1 | One-cycle latch pulse |
| data_o | output | 218 | Parallel latched payload |

## Verification
A shift register that has slipped by even one position shows up at the ports at the next latch, or as a pulse that never comes because the header no longer decodes. A bad interval count or a bad clamp moves the pulse away from cycle T+3, and the bench checks the pulse at that exact cycle. A detector that stays armed, or a guard window that leaks an edge, causes a second pulse or a misaligned payload within one timeout of the first pulse.

// File: rtl/slt_pkg.sv
package slt_pkg;
    localparam int unsigned SLT_SR_W        = 224;
    localparam int unsigned SLT_CMD_W       = 6;
    localparam logic [5:0]  SLT_CMD_WRITE   = 6'h25;
    localparam int unsigned SLT_MULT_SH     = 3;
    localparam int unsigned SLT_MIN_TO      = 8;
    localparam int unsigned SLT_MAX_TO      = 16384;
    localparam int unsigned SLT_GUARD       = 8;
    localparam int unsigned SLT_SYNC_STAGES = 2;
endpackage

// File: rtl/slt_sync_edge.sv
module slt_sync_edge #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic sdat_i,
    output logic rise_o,
    output logic dat_o
);
    typedef struct packed {
        logic [STAGES-1:0] clk_sync;
        logic [STAGES-1:0] dat_sync;
        logic              clk_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.clk_sync = {s_q.clk_sync[STAGES-2:0], sclk_i};
        s_d.dat_sync = {s_q.dat_sync[STAGES-2:0], sdat_i};
        s_d.clk_prev = s_q.clk_sync[STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign rise_o = s_q.clk_sync[STAGES-1] & ~s_q.clk_prev;
    assign dat_o  = s_q.dat_sync[STAGES-1];
endmodule

// File: rtl/slt_idle_timer.sv
module slt_idle_timer #(
    parameter int unsigned CNT_W   = 15,
    parameter int unsigned MULT_SH = 3,
    parameter int unsigned MIN_TO  = 8,
    parameter int unsigned MAX_TO  = 16384,
    parameter int unsigned GUARD   = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic rise_i,
    input  logic cmd_ok_i,
    output logic accept_o,
    output logic fire_o
);
    localparam int unsigned PROD_W = CNT_W + MULT_SH;
    localparam int unsigned GRD_W  = $clog2(GUARD + 1);
    localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
    localparam logic [PROD_W-1:0] TO_MAX   = PROD_W'(MAX_TO);
    localparam logic [PROD_W-1:0] TO_MIN   = PROD_W'(MIN_TO);
    localparam logic [GRD_W-1:0]  GRD_LOAD = GRD_W'(GUARD);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] period;
        logic             armed;
        logic [GRD_W-1:0] guard;
    } tmr_t;

    tmr_t t_d, t_q;
    logic [PROD_W-1:0] prod, limit, cnt_w;
    logic              expire;

    always_comb begin
        prod  = PROD_W'(t_q.period) << MULT_SH;
        if (prod > TO_MAX)      limit = TO_MAX;
        else if (prod < TO_MIN) limit = TO_MIN;
        else                    limit = prod;
        cnt_w    = PROD_W'(t_q.cnt);
        expire   = t_q.armed && (cnt_w >= limit);
        fire_o   = expire && cmd_ok_i;
        accept_o = rise_i && (t_q.guard == '0) && !fire_o;

        t_d = t_q;
        if (accept_o) begin
            t_d.cnt    = CNT_W'(1);
            t_d.period = t_q.cnt;
            t_d.armed  = 1'b1;
        end else begin
            t_d.cnt = (t_q.cnt == CNT_MAX) ? t_q.cnt : t_q.cnt + 1'b1;
            if (expire) t_d.armed = 1'b0;
        end
        if (fire_o)                t_d.guard = GRD_LOAD;
        else if (t_q.guard != '0)  t_d.guard = t_q.guard - 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end
endmodule

// File: rtl/slt_latch_gen.sv
module slt_latch_gen import slt_pkg::*; #(
    parameter int unsigned SR_W        = SLT_SR_W,
    parameter int unsigned CMD_W       = SLT_CMD_W,
    parameter logic [CMD_W-1:0] CMD_CODE = SLT_CMD_WRITE,
    parameter int unsigned MULT_SH     = SLT_MULT_SH,
    parameter int unsigned MIN_TO      = SLT_MIN_TO,
    parameter int unsigned MAX_TO      = SLT_MAX_TO,
    parameter int unsigned GUARD       = SLT_GUARD,
    parameter int unsigned SYNC_STAGES = SLT_SYNC_STAGES
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   sclk_i,
    input  logic                   sdat_i,
    output logic                   latch_pulse_o,
    output logic [SR_W-CMD_W-1:0]  data_o
);
    localparam int unsigned PAY_W = SR_W - CMD_W;
    localparam int unsigned CNT_W = $clog2(MAX_TO) + 1;

    typedef struct packed {
        logic [SR_W-1:0]  sr;
        logic [PAY_W-1:0] data;
        logic             pulse;
    } lg_t;

    lg_t  st_d, st_q;
    logic rise, dat_s, accept, fire, cmd_ok;
    logic [SR_W-1:0] shreg;

    slt_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sclk_i(sclk_i),
        .sdat_i(sdat_i),
        .rise_o(rise),
        .dat_o (dat_s)
    );

    slt_idle_timer #(
        .CNT_W  (CNT_W),
        .MULT_SH(MULT_SH),
        .MIN_TO (MIN_TO),
        .MAX_TO (MAX_TO),
        .GUARD  (GUARD)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rise_i  (rise),
        .cmd_ok_i(cmd_ok),
        .accept_o(accept),
        .fire_o  (fire)
    );

    always_comb begin
        cmd_ok     = (st_q.sr[SR_W-1 -: CMD_W] == CMD_CODE);
        st_d       = st_q;
        st_d.pulse = fire;
        if (accept) st_d.sr   = {st_q.sr[SR_W-2:0], dat_s};
        if (fire)   st_d.data = st_q.sr[PAY_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign shreg         = st_q.sr;
    assign latch_pulse_o = st_q.pulse;
    assign data_o        = st_q.data;
endmodule

// File: rtl/slt_latch_gen_chk.sv
module slt_latch_gen_chk import slt_pkg::*; #(
    parameter int unsigned SR_W  = SLT_SR_W,
    parameter int unsigned CMD_W = SLT_CMD_W,
    parameter logic [CMD_W-1:0] CMD_CODE = SLT_CMD_WRITE,
    parameter int unsigned PAY_W = SR_W - CMD_W
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             latch_pulse_o,
    input logic [PAY_W-1:0] data_o,
    input logic [SR_W-1:0]  sr_i
);
    // R7
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_pulse_o |=> !latch_pulse_o);

    // R6
    data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !latch_pulse_o |-> $stable(data_o));

    // R5
    cmd_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_pulse_o |-> ($past(sr_i[SR_W-1 -: CMD_W]) == CMD_CODE));

    // R6
    payload_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_pulse_o |-> (data_o == $past(sr_i[PAY_W-1:0])));

    // R8
    guard_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        latch_pulse_o |=> $stable(sr_i));
endmodule

bind slt_latch_gen slt_latch_gen_chk u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .latch_pulse_o(latch_pulse_o),
    .data_o       (data_o),
    .sr_i         (shreg)
);

// File: tb/test_slt_latch_gen.sv
module test_slt_latch_gen;
    localparam int CLK_PERIOD = 10;
    localparam int SR_W  = 224;
    localparam int PAY_W = 218;

    logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, sdat = 1'b0;
    logic             pulse;
    logic [PAY_W-1:0] data;

    always #(CLK_PERIOD/2) clk = ~clk;

    slt_latch_gen i_slt_latch_gen (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sclk_i       (sclk),
        .sdat_i       (sdat),
        .latch_pulse_o(pulse),
        .data_o       (data)
    );

    int     checks = 0, fails = 0, pulses = 0;
    longint cyc = 0, last_rise = 0;
    bit     done = 1'b0;

    typedef struct {
        longint           at;
        logic [PAY_W-1:0] d;
        string            ttag;
        string            dtag;
    } exp_t;
    exp_t sb[$];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint t_of(longint p);
        longint v = 8 * p;
        if (v < 8)     v = 8;
        if (v > 16384) v = 16384;
        return v;
    endfunction

    task automatic chk_num(input bit ok, input string req, input string what,
                           input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_vec(input bit ok, input string req, input string what,
                           input logic [PAY_W-1:0] act, input logic [PAY_W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(input bit b, input int hi, input int lo);
        sdat = b;
        sclk = 1'b1;
        last_rise = cyc;
        repeat (hi) @(negedge clk);
        sclk = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    task automatic send_frame(input logic [SR_W-1:0] f, input int hi, input int lo);
        for (int i = SR_W - 1; i >= 0; i--) send_bit(f[i], hi, lo);
    endtask

    task automatic push_exp(input logic [PAY_W-1:0] d, input longint period,
                            input string ttag, input string dtag);
        exp_t e;
        e.at   = last_rise + t_of(period) + 3;
        e.d    = d;
        e.ttag = ttag;
        e.dtag = dtag;
        sb.push_back(e);
    endtask

    // monitor: pops the scoreboard on every pulse
    always @(negedge clk) begin
        if (rst_n && pulse) begin
            pulses++;
            if (sb.size() == 0) begin
                chk_num(1'b0, "R7", "unexpected latch pulse at cycle", cyc, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk_num(cyc == e.at, e.ttag, "pulse cycle", cyc, e.at);
                chk_vec(data == e.d, e.dtag, "latched payload", data, e.d);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    logic [SR_W-1:0] fa, fc, fb, fm, ff;
    logic [SR_W-2:0] fg;

    initial begin
        fa = {6'h25, {27{8'hC3}}, 2'b10};
        fc = {6'h25, {54{4'h6}}, 2'b00};
        fb = {6'h25, {109{2'b01}}};
        fm = {6'h24, {218{1'b1}}};
        ff = {6'h25, {54{4'hA}}, 2'b11};
        fg = {5'b00101, {72{3'b011}}, 2'b01};

        repeat (5) @(negedge clk);
        // R1: reset values
        chk_num(pulse == 1'b0, "R1", "pulse in reset", pulse, 0);
        chk_vec(data == '0, "R1", "data in reset", data, '0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R2 R3: frame at 4-cycle bit period, T = 32
        send_frame(fa, 2, 2);
        push_exp(fa[PAY_W-1:0], 4, "R3", "R2");
        repeat (60) @(negedge clk);

        // R4 R9: last interval 33000 cycles, counter saturates, T clamps to 16384
        for (int i = SR_W - 1; i >= 2; i--) send_bit(fc[i], 2, 2);
        send_bit(fc[1], 2, 32998);
        // R5: early expiry with header 6'h12 must not latch
        chk_vec(data == fa[PAY_W-1:0], "R5", "data after mismatched expiry", data, fa[PAY_W-1:0]);
        send_bit(fc[0], 2, 2);
        push_exp(fc[PAY_W-1:0], 33000, "R4 R9", "R6");
        repeat (16420) @(negedge clk);

        // R3: fastest clock, 2-cycle bit period, T = 16
        send_frame(fb, 1, 1);
        push_exp(fb[PAY_W-1:0], 2, "R3", "R6");
        repeat (40) @(negedge clk);

        // R5: wrong header, no pulse, data unchanged
        send_frame(fm, 2, 2);
        repeat (300) @(negedge clk);
        chk_vec(data == fb[PAY_W-1:0], "R5", "data after wrong header", data, fb[PAY_W-1:0]);

        // R8: edge inside guard window is dropped
        send_frame(ff, 2, 2);
        push_exp(ff[PAY_W-1:0], 4, "R3", "R6");
        @(negedge clk);
        while (!pulse) @(negedge clk);
        sdat = 1'b0;
        sclk = 1'b1;
        repeat (2) @(negedge clk);
        sclk = 1'b0;
        repeat (30) @(negedge clk);
        for (int i = SR_W - 2; i >= 0; i--) send_bit(fg[i], 3, 3);
        push_exp(fg[PAY_W-1:0], 6, "R3", "R8");
        repeat (600) @(negedge clk);

        // R7: exactly one pulse per committed frame, nothing left pending
        chk_num(pulses == 5, "R7", "total pulses", pulses, 5);
        chk_num(sb.size() == 0, "R7", "pending expected pulses", sb.size(), 0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule